// File: doc/BRIEF.md
# Weight-Stationary Systolic Matrix Unit

This block multiplies a stream of signed 8-bit activation vectors by a stationary N×N weight tile. Each cell of the grid holds one weight. Activations move one cell to the right per clock, and partial sums move one cell down per clock. The unit delays each input row so that its values meet the partial sums at the right moment. It also re-aligns the column outputs at the bottom edge, so that every result vector reaches a per-column accumulator array in a single write. The default N is 4, and the structure is written to scale to 256.

A new weight tile is written row by row into a shadow staging set. This can happen while the current tile is still computing. Once the tile is complete, it is committed to all cells in one clock, but only when no vector is still inside the array. A pass is a run of activation vectors whose final vector carries a last flag. The vectors of a pass land in consecutive accumulator rows, starting at row 0. Each vector either overwrites its row or adds to it. When the final vector of a pass has been accumulated, a one-cycle done pulse is raised. Software reads the accumulator rows through a registered read port.

Top module: `ws_matrix_unit`

## Requirements
- R1: After synchronous reset, `done` is 0, `rd_data` is 0, every accumulator row reads 0, all active weights are 0 (so any vector produces zero results), and staging is empty.
- R2: The result for a vector x is y[j] = sum over i of x[i]·W[i][j], with signed operands and a 32-bit two's-complement sum. Element i of `act_vec` is bits [8i+7:8i]. The k-th vector of a pass (k counted from 0) goes to accumulator row k mod DEPTH. Column j occupies bits [32j+31:32j] of a row.
- R3: A vector sampled at clock edge t is written to the accumulator at edge t+2N-1. A new vector may be accepted on every clock.
- R4: Each accepted `wt_valid` cycle writes the next staging row in order, starting at row 0. Row i holds W[i][*], and W[i][j] is bits [8j+7:8j] of `wt_row`. After the N-th row, the tile is pending commit.
- R5: A pending tile is committed at the first edge at which `act_valid` is low and no vector is in flight. At the earliest, this is the edge after the one that completed the tile. Vectors accepted after the commit use the new tile.
- R6: While any vector is in flight, or `act_valid` is high, commit is held off. Every vector is computed entirely with the tile that was active when it was accepted.
- R7: A `wt_valid` cycle seen while a tile is pending is ignored. It changes neither the staging contents nor the row order.
- R8: With `acc_add` = 1, a vector's result is added to the stored row. With `acc_add` = 0, it overwrites the row. The choice is made per vector.
- R9: `done` is high for exactly the one cycle after the edge at which a vector flagged `act_last` is accumulated. Back-to-back one-vector passes give consecutive pulses.
- R10: `rd_data` shows row `rd_addr` one cycle after it is sampled. If a write to the same row happens at the same edge, `rd_data` shows the value from before that write.
- R11: Extreme operands do not overflow the column sum. For example, N products of (−128)·(−128) give exactly N·16384.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wt_valid | input | 1 | Staging row write strobe |
| wt_row | input | N*8 | One weight row, column j in byte j |
| act_valid | input | 1 | Activation vector strobe |
| act_vec | input | N*8 | Activation vector, row i in byte i |
| act_last | input | 1 | Marks the final vector of a pass |
| acc_add | input | 1 | 1 = add to row, 0 = overwrite row |
| rd_addr | input | log2(DEPTH) | Accumulator read row |
| rd_data | output | N*32 | Registered accumulator row |
| done | output | 1 | Pass completion pulse |

## Verification
The unit is driven with random tiles and vectors, and a behavioural model predicts every output on every clock. Several stimulus patterns are used. Isolated vectors and back-to-back streams separate a correct skew from an off-by-one alignment. A pass longer than DEPTH exercises row wrap-around. Tile loads are placed in three positions: in idle time, just before a vector, and overlapping a stream. These separate a correct commit hold-off from an early commit that would mix tiles inside a vector. Extra rows sent while a tile is pending expose accidental acceptance. Add-mode passes, same-row read-during-write and all-extreme operands cover accumulation order, read timing and sum width.

// File: rtl/wsmu_pkg.sv
package wsmu_pkg;
  typedef enum logic {
    ACC_OVERWRITE = 1'b0,
    ACC_ADD       = 1'b1
  } acc_mode_e;
endpackage

// File: rtl/wsmu_delay.sv
module wsmu_delay #(
  parameter int W = 8,
  parameter int D = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  generate
    if (D == 0) begin : g_pass
      logic unused_d0;
      assign unused_d0 = clk ^ rst;
      assign dout = din;
    end else begin : g_line
      logic [W-1:0] sr [D];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int k = 0; k < D; k++) sr[k] <= '0;
        end else begin
          sr[0] <= din;
          for (int k = 1; k < D; k++) sr[k] <= sr[k-1];
        end
      end
      assign dout = sr[D-1];
    end
  endgenerate
endmodule

// File: rtl/wsmu_pe.sv
module wsmu_pe #(
  parameter int OPW = 8,
  parameter int PSW = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  commit,
  input  logic [OPW-1:0]        w_stg,
  input  logic signed [OPW-1:0] a_in,
  input  logic signed [PSW-1:0] p_in,
  output logic signed [OPW-1:0] a_out,
  output logic signed [PSW-1:0] p_out
);
  localparam int PRW = 2 * OPW;

  logic signed [OPW-1:0] w_q;
  logic signed [PRW-1:0] prod;
  logic signed [PSW-1:0] prod_x;

  assign prod   = a_in * w_q;
  assign prod_x = {{(PSW-PRW){prod[PRW-1]}}, prod};

  always_ff @(posedge clk) begin
    if (rst) begin
      w_q   <= '0;
      a_out <= '0;
      p_out <= '0;
    end else begin
      if (commit) w_q <= w_stg;
      a_out <= a_in;
      p_out <= p_in + prod_x;
    end
  end
endmodule

// File: rtl/wsmu_wstage.sv
module wsmu_wstage #(
  parameter int N   = 4,
  parameter int OPW = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wt_valid,
  input  logic [N*OPW-1:0]   wt_row,
  input  logic               busy,
  output logic [N*N*OPW-1:0] stg_flat,
  output logic               commit
);
  localparam int CW = $clog2(N + 1);

  logic [N*OPW-1:0] stg [N];
  logic [CW-1:0]    cnt;
  logic             pending;

  assign commit = pending & ~busy;

  always_ff @(posedge clk) begin
    if (wt_valid && !pending) stg[cnt] <= wt_row;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      pending <= 1'b0;
    end else if (commit) begin
      pending <= 1'b0;
    end else if (wt_valid && !pending) begin
      if (cnt == CW'(N - 1)) begin
        cnt     <= '0;
        pending <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  generate
    for (genvar r = 0; r < N; r++) begin : g_row
      assign stg_flat[r*N*OPW +: N*OPW] = stg[r];
    end
  endgenerate

  assert_tile_pending_R4: assert property (@(posedge clk) disable iff (rst)
    (wt_valid && !pending && cnt == CW'(N - 1)) |=> pending);
  assert_commit_clears_R5: assert property (@(posedge clk) disable iff (rst)
    (pending && !busy) |=> !pending);
  assert_load_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (wt_valid && pending) |=> $stable(cnt));
endmodule

// File: rtl/wsmu_acc.sv
module wsmu_acc
  import wsmu_pkg::*;
#(
  parameter int N     = 4,
  parameter int PSW   = 32,
  parameter int DEPTH = 8,
  parameter int AW    = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_valid,
  input  logic               wr_add,
  input  logic               wr_last,
  input  logic [AW-1:0]      wr_addr,
  input  logic [N*PSW-1:0]   wr_data,
  input  logic [AW-1:0]      rd_addr,
  output logic [N*PSW-1:0]   rd_data,
  output logic               done
);
  logic [N*PSW-1:0] acc [DEPTH];
  logic [N*PSW-1:0] nxt;
  acc_mode_e        mode;

  assign mode = acc_mode_e'(wr_add);

  generate
    for (genvar j = 0; j < N; j++) begin : g_col
      assign nxt[j*PSW +: PSW] = (mode == ACC_ADD)
        ? acc[wr_addr][j*PSW +: PSW] + wr_data[j*PSW +: PSW]
        : wr_data[j*PSW +: PSW];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < DEPTH; k++) acc[k] <= '0;
      rd_data <= '0;
      done    <= 1'b0;
    end else begin
      rd_data <= acc[rd_addr];
      if (wr_valid) acc[wr_addr] <= nxt;
      done <= wr_valid & wr_last;
    end
  end

  assert_overwrite_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_add) |=> acc[$past(wr_addr)] == $past(wr_data));
endmodule

// File: rtl/ws_matrix_unit.sv
module ws_matrix_unit #(
  parameter int N     = 4,
  parameter int OPW   = 8,
  parameter int PSW   = 32,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wt_valid,
  input  logic [N*OPW-1:0] wt_row,
  input  logic             act_valid,
  input  logic [N*OPW-1:0] act_vec,
  input  logic             act_last,
  input  logic             acc_add,
  input  logic [AW-1:0]    rd_addr,
  output logic [N*PSW-1:0] rd_data,
  output logic             done
);
  localparam int LAT = 2 * N - 1;

  logic                  busy, commit;
  logic [N*N*OPW-1:0]    stg_flat;
  logic signed [OPW-1:0] a_h [N][N+1];
  logic signed [PSW-1:0] p_v [N+1][N];
  logic [N*PSW-1:0]      col_out;
  logic [N-1:0]          unused_edge;
  logic [AW-1:0]         vidx;
  logic [LAT-1:0]        m_v, m_l, m_a;
  logic [AW-1:0]         m_addr [LAT];

  assign busy = act_valid | (|m_v);

  wsmu_wstage #(.N(N), .OPW(OPW)) u_wstage (
    .clk(clk), .rst(rst), .wt_valid(wt_valid), .wt_row(wt_row),
    .busy(busy), .stg_flat(stg_flat), .commit(commit)
  );

  // vector index within a pass and control pipeline matching the array latency
  always_ff @(posedge clk) begin
    if (rst) begin
      vidx <= '0;
      m_v  <= '0;
      m_l  <= '0;
      m_a  <= '0;
      for (int k = 0; k < LAT; k++) m_addr[k] <= '0;
    end else begin
      if (act_valid) begin
        if (act_last || vidx == AW'(DEPTH - 1)) vidx <= '0;
        else vidx <= vidx + 1'b1;
      end
      m_v <= {m_v[LAT-2:0], act_valid};
      m_l <= {m_l[LAT-2:0], act_last};
      m_a <= {m_a[LAT-2:0], acc_add};
      m_addr[0] <= vidx;
      for (int k = 1; k < LAT; k++) m_addr[k] <= m_addr[k-1];
    end
  end

  generate
    for (genvar i = 0; i < N; i++) begin : g_skew
      logic [OPW-1:0] row_d;
      wsmu_delay #(.W(OPW), .D(i)) u_skew (
        .clk(clk), .rst(rst), .din(act_vec[i*OPW +: OPW]), .dout(row_d)
      );
      assign a_h[i][0] = row_d;
      assign unused_edge[i] = ^a_h[i][N];
    end

    for (genvar j = 0; j < N; j++) begin : g_top
      assign p_v[0][j] = '0;
    end

    for (genvar i = 0; i < N; i++) begin : g_r
      for (genvar j = 0; j < N; j++) begin : g_c
        wsmu_pe #(.OPW(OPW), .PSW(PSW)) u_pe (
          .clk(clk), .rst(rst), .commit(commit),
          .w_stg(stg_flat[(i*N+j)*OPW +: OPW]),
          .a_in(a_h[i][j]), .p_in(p_v[i][j]),
          .a_out(a_h[i][j+1]), .p_out(p_v[i+1][j])
        );
      end
    end

    for (genvar j = 0; j < N; j++) begin : g_deskew
      wsmu_delay #(.W(PSW), .D(N-1-j)) u_dsk (
        .clk(clk), .rst(rst), .din(p_v[N][j]), .dout(col_out[j*PSW +: PSW])
      );
    end
  endgenerate

  wsmu_acc #(.N(N), .PSW(PSW), .DEPTH(DEPTH), .AW(AW)) u_acc (
    .clk(clk), .rst(rst),
    .wr_valid(m_v[LAT-1]), .wr_add(m_a[LAT-1]), .wr_last(m_l[LAT-1]),
    .wr_addr(m_addr[LAT-1]), .wr_data(col_out),
    .rd_addr(rd_addr), .rd_data(rd_data), .done(done)
  );

  assert_commit_held_R6: assert property (@(posedge clk) disable iff (rst)
    busy |-> !commit);
  assert_done_source_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(m_v[LAT-1] && m_l[LAT-1]));
endmodule

// File: tb/test_ws_matrix_unit.sv
`timescale 1ns/1ps
module test_ws_matrix_unit;
  localparam int N = 4;
  localparam int DEPTH = 8;
  localparam int AW = 3;
  localparam int LAT = 2 * N - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wt_valid = 1'b0;
  logic [N*8-1:0] wt_row = '0;
  logic act_valid = 1'b0;
  logic [N*8-1:0] act_vec = '0;
  logic act_last = 1'b0;
  logic acc_add = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [N*32-1:0] rd_data;
  logic done;

  always #2.5 clk = ~clk;

  ws_matrix_unit #(.N(N), .OPW(8), .PSW(32), .DEPTH(DEPTH)) i_ws_matrix_unit (
    .clk(clk), .rst(rst), .wt_valid(wt_valid), .wt_row(wt_row),
    .act_valid(act_valid), .act_vec(act_vec), .act_last(act_last),
    .acc_add(acc_add), .rd_addr(rd_addr), .rd_data(rd_data), .done(done)
  );

  int checks = 0;
  int fails = 0;
  string cur_req = "R1";
  bit finished = 1'b0;
  bit rd_hold = 1'b0;
  logic [AW-1:0] rd_fix = '0;
  int sweep = 0;

  // ---------------- behavioural reference ----------------
  typedef struct packed {
    int            wc;
    logic [AW-1:0] addr;
    logic          add;
    logic          last;
    logic [N*32-1:0] y;
  } wr_t;

  wr_t q[$];
  int Wa [N][N];
  int Ws [N][N];
  int s_cnt;
  bit s_pend;
  logic [31:0] acc_m [DEPTH][N];
  int vidx_m;
  int cyc = 0;
  logic [N*32-1:0] exp_rd = '0;
  logic exp_done = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      q.delete();
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++) begin Wa[i][j] = 0; Ws[i][j] = 0; end
      for (int a = 0; a < DEPTH; a++)
        for (int j = 0; j < N; j++) acc_m[a][j] = '0;
      s_cnt = 0; s_pend = 0; vidx_m = 0;
      exp_rd = '0; exp_done = 0;
    end else begin
      bit busy_m;
      bit do_commit;
      for (int j = 0; j < N; j++) exp_rd[j*32 +: 32] = acc_m[rd_addr][j];
      busy_m = act_valid || (q.size() != 0);
      do_commit = s_pend && !busy_m;
      exp_done = 0;
      if (q.size() != 0 && q[0].wc == cyc) begin
        wr_t e;
        e = q.pop_front();
        for (int j = 0; j < N; j++)
          acc_m[e.addr][j] = e.add ? acc_m[e.addr][j] + e.y[j*32 +: 32] : e.y[j*32 +: 32];
        exp_done = e.last;
      end
      if (act_valid) begin
        wr_t n;
        for (int j = 0; j < N; j++) begin
          int s;
          s = 0;
          for (int i = 0; i < N; i++) s += $signed(act_vec[i*8 +: 8]) * Wa[i][j];
          n.y[j*32 +: 32] = s;
        end
        n.wc = cyc + LAT; n.addr = AW'(vidx_m); n.add = acc_add; n.last = act_last;
        q.push_back(n);
        vidx_m = (act_last || vidx_m == DEPTH - 1) ? 0 : vidx_m + 1;
      end
      if (do_commit) begin
        for (int i = 0; i < N; i++)
          for (int j = 0; j < N; j++) Wa[i][j] = Ws[i][j];
        s_pend = 0;
      end else if (wt_valid && !s_pend) begin
        for (int j = 0; j < N; j++) Ws[s_cnt][j] = $signed(wt_row[j*8 +: 8]);
        if (s_cnt == N - 1) begin s_cnt = 0; s_pend = 1; end
        else s_cnt++;
      end
    end
    cyc++;
  end

  // ---------------- comparison every clock ----------------
  always @(negedge clk) begin
    if (!finished) begin
      checks++;
      if (done !== exp_done) begin
        fails++;
        $display("FAIL %s done cyc=%0d actual=%0b expected=%0b", cur_req, cyc, done, exp_done);
      end
      checks++;
      if (rd_data !== exp_rd) begin
        fails++;
        $display("FAIL %s rd_data cyc=%0d actual=%h expected=%h", cur_req, cyc, rd_data, exp_rd);
      end
      sweep++;
      rd_addr = rd_hold ? rd_fix : AW'(sweep);
    end
  end

  // ---------------- stimulus ----------------
  function automatic logic [N*8-1:0] rnd_bytes();
    logic [N*8-1:0] v;
    for (int i = 0; i < N; i++) v[i*8 +: 8] = 8'($urandom);
    return v;
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic stream(input int n, input bit add);
    for (int v = 0; v < n; v++) begin
      act_valid = 1; act_vec = rnd_bytes(); act_last = (v == n - 1); acc_add = add;
      @(negedge clk);
    end
    act_valid = 0; act_last = 0; acc_add = 0;
  endtask

  task automatic send_fixed(input logic [7:0] b, input bit last, input bit add);
    act_valid = 1; act_vec = {N{b}}; act_last = last; acc_add = add;
    @(negedge clk);
    act_valid = 0; act_last = 0; acc_add = 0;
  endtask

  task automatic load_tile(input int kind, input int rows);
    for (int r = 0; r < rows; r++) begin
      wt_valid = 1;
      case (kind)
        1: wt_row = {N{8'h80}};
        2: wt_row = {N{8'h7F}};
        default: wt_row = rnd_bytes();
      endcase
      @(negedge clk);
    end
    wt_valid = 0;
  endtask

  initial begin
    #(5.0 * 50000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state, zero weights give zero results
    cur_req = "R1"; idle(10); stream(2, 0); idle(12);
    // R4 / R2: tile load then passes, including wrap past DEPTH
    cur_req = "R4"; load_tile(0, N); idle(2);
    cur_req = "R2"; stream(3, 0); idle(12); stream(10, 0); idle(12);
    // R3: back-to-back vectors and fixed latency
    cur_req = "R3"; stream(6, 0); idle(10);
    // R5: commit with an idle edge, and a vector right after completion
    cur_req = "R5"; load_tile(0, N); idle(1); stream(2, 0); idle(10);
    load_tile(0, N); stream(2, 0); idle(12); stream(1, 0); idle(10);
    // R6: load overlapping a stream
    cur_req = "R6";
    fork
      stream(12, 0);
      begin idle(2); load_tile(0, N); end
    join
    idle(12); stream(3, 0); idle(12);
    // R7: extra rows while pending are ignored
    cur_req = "R7";
    fork
      stream(14, 0);
      begin load_tile(0, N); load_tile(0, 3); end
    join
    idle(12); stream(3, 0); idle(10);
    // R8: add mode per vector
    cur_req = "R8"; stream(4, 1); idle(10); stream(4, 1); stream(2, 0); idle(12);
    // R9: consecutive single-vector passes
    cur_req = "R9"; stream(1, 0); stream(1, 1); stream(1, 0); stream(1, 1); idle(12);
    // R10: read of the row being written
    cur_req = "R10"; rd_hold = 1; rd_fix = '0;
    stream(1, 1); idle(3); stream(1, 1); idle(10);
    rd_fix = AW'(1); stream(2, 1); idle(10); rd_hold = 0;
    // R11: extreme operands
    cur_req = "R11"; load_tile(1, N); idle(2);
    send_fixed(8'h80, 0, 0); send_fixed(8'h7F, 1, 0); idle(10);
    send_fixed(8'h80, 0, 1); send_fixed(8'h80, 1, 1); idle(10);
    load_tile(2, N); idle(2); send_fixed(8'h80, 1, 0); idle(12);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule